// File: doc/BRIEF.md
# Directory-Coherence Cache Block Controller

This controller sits beside one cache frame of a processor in a shared-memory system where coherence is kept by a home directory instead of a snooped bus. It keeps the frame in one of three states: Invalid, Shared (readable copy) or Exclusive (the only writable copy). Any processor access that the frame cannot satisfy locally becomes an explicit request message to the home node. The processor is held stalled until the home node answers with a data reply.

Commands from the home node arrive on an in-order message input. Invalidate drops a shared copy. Fetch asks the owner to return its dirty word and keep a readable copy. Fetch-and-invalidate asks the owner to return the word and give up the frame. Outgoing traffic leaves through a single valid/ready message port. Each outgoing message carries a type code, the node number of this cache and the block address. A write-back message also carries the data word. Only one request is outstanding at a time.

Top module: `dir_cache_ctrl`

## Requirements
- R1: After reset the frame is Invalid (`line_state` = 0; Shared = 1, Exclusive = 2), `out_valid` and `cpu_ready` are low, and `in_ready` is high.
- R2: A read whose address matches the frame tag while the frame is Shared or Exclusive completes in the same cycle (`cpu_ready` high, `cpu_rdata` = stored word) and sends no message.
- R3: A read that misses sends a read-miss message (type 0, `out_node` = NODE_ID, the read address, data 0). It holds `cpu_ready` low until a data reply (type 6) arrives. In that reply cycle it returns the reply word, and it leaves the frame Shared.
- R4: A write to a frame that is Invalid, Shared, or tagged with another address (not Exclusive) sends a write-miss message (type 1, address, data 0). It completes on the data reply and leaves the frame Exclusive, holding the written word.
- R5: A write to the matching Exclusive frame completes in the same cycle with no message, and a later read returns the new word.
- R6: An invalidate message (type 3) for the tagged address while Shared makes the frame Invalid.
- R7: A fetch message (type 4) for the tagged address while Exclusive produces a write-back message (type 2, tag, stored word) and leaves the frame Shared.
- R8: A fetch-and-invalidate message (type 5) for the tagged address while Exclusive produces a write-back message and leaves the frame Invalid.
- R9: A miss while Exclusive for another address first writes the old block back (type 2, old tag, old word), then sends the read-miss or write-miss for the new address, in that order.
- R10: A home message whose address differs from the tag, or that does not apply to the current state, is consumed with no state change and no message.
- R11: While `out_valid` is high and `out_ready` low, the outgoing message stays asserted with unchanged type, address and data.
- R12: A home message present in the same cycle as a processor access is served first, and the access stalls for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor access pending, held until `cpu_ready` |
| cpu_write | input | 1 | Access is a write |
| cpu_addr | input | AW | Block address of the access |
| cpu_wdata | input | DW | Write word |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read word, valid with `cpu_ready` |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network accepts the outgoing message |
| out_type | output | 3 | Outgoing message type code |
| out_node | output | IDW | Node number of this cache |
| out_addr | output | AW | Block address of the message |
| out_data | output | DW | Write-back word (0 for miss requests) |
| in_valid | input | 1 | Home message valid |
| in_ready | output | 1 | Controller accepts the home message |
| in_type | input | 3 | Home message type code |
| in_addr | input | AW | Block address of the home message |
| in_data | input | DW | Reply word |
| line_state | output | 2 | Frame coherence state |

## Verification
The hardest case to reach is the two-message eviction of R9. The frame must first be made Exclusive through a write miss and its reply. A conflicting access then has to be issued while the write-back and the following miss are checked in order by the scoreboard. A stalled outgoing port during a fetch-and-invalidate is forced by lowering `out_ready` before the home message arrives. The same-cycle collision of R12 is produced by raising a processor hit and an unrelated home message together.

// File: rtl/dir_cache_ctrl.sv
module dir_cache_ctrl #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int IDW     = 4,
  parameter int NODE_ID = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_valid,
  input  logic           cpu_write,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic           cpu_ready,
  output logic [DW-1:0]  cpu_rdata,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2:0]     out_type,
  output logic [IDW-1:0] out_node,
  output logic [AW-1:0]  out_addr,
  output logic [DW-1:0]  out_data,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     in_type,
  input  logic [AW-1:0]  in_addr,
  input  logic [DW-1:0]  in_data,
  output logic [1:0]     line_state
);

  localparam logic [2:0] T_RMISS = 3'd0;
  localparam logic [2:0] T_WMISS = 3'd1;
  localparam logic [2:0] T_WB    = 3'd2;
  localparam logic [2:0] T_INV   = 3'd3;
  localparam logic [2:0] T_FETCH = 3'd4;
  localparam logic [2:0] T_FINV  = 3'd5;
  localparam logic [2:0] T_REPLY = 3'd6;

  localparam logic [1:0] L_INV = 2'd0;
  localparam logic [1:0] L_SHD = 2'd1;
  localparam logic [1:0] L_EXC = 2'd2;

  typedef enum logic [2:0] {P_IDLE, P_WB, P_MISS, P_WAIT, P_RWB} phase_t;

  phase_t          phase;
  logic [1:0]      lst;
  logic [AW-1:0]   tag;
  logic [DW-1:0]   word;
  logic            o_vld;
  logic [2:0]      o_type;
  logic [AW-1:0]   o_addr;
  logic [DW-1:0]   o_data;

  logic tag_hit, rd_hit, wr_hit, hit, idle, reply, own_msg, owner_req;
  logic [2:0] miss_t;

  assign tag_hit   = (lst != L_INV) && (tag == cpu_addr);
  assign rd_hit    = !cpu_write && tag_hit;
  assign wr_hit    = cpu_write && tag_hit && (lst == L_EXC);
  assign hit       = rd_hit || wr_hit;
  assign idle      = (phase == P_IDLE);
  assign reply     = (phase == P_WAIT) && in_valid && (in_type == T_REPLY);
  assign own_msg   = in_valid && (in_addr == tag);
  assign owner_req = own_msg && (lst == L_EXC) && (in_type == T_FETCH || in_type == T_FINV);
  assign miss_t    = cpu_write ? T_WMISS : T_RMISS;

  assign in_ready   = idle || (phase == P_WAIT);
  assign cpu_ready  = (idle && !in_valid && cpu_valid && hit) || reply;
  assign cpu_rdata  = reply ? in_data : word;
  assign out_valid  = o_vld;
  assign out_type   = o_type;
  assign out_node   = IDW'(NODE_ID);
  assign out_addr   = o_addr;
  assign out_data   = o_data;
  assign line_state = lst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= P_IDLE;
      lst    <= L_INV;
      tag    <= '0;
      word   <= '0;
      o_vld  <= 1'b0;
      o_type <= T_RMISS;
      o_addr <= '0;
      o_data <= '0;
    end else begin
      case (phase)
        P_IDLE: begin
          if (in_valid) begin
            if (own_msg && in_type == T_INV && lst == L_SHD)
              lst <= L_INV;
            if (owner_req) begin
              lst    <= (in_type == T_FETCH) ? L_SHD : L_INV;
              o_vld  <= 1'b1;
              o_type <= T_WB;
              o_addr <= tag;
              o_data <= word;
              phase  <= P_RWB;
            end
          end else if (cpu_valid) begin
            if (wr_hit) begin
              word <= cpu_wdata;
            end else if (!rd_hit) begin
              o_vld <= 1'b1;
              if (lst == L_EXC) begin
                o_type <= T_WB;
                o_addr <= tag;
                o_data <= word;
                lst    <= L_INV;
                phase  <= P_WB;
              end else begin
                o_type <= miss_t;
                o_addr <= cpu_addr;
                o_data <= '0;
                phase  <= P_MISS;
              end
            end
          end
        end
        P_WB: begin
          if (out_ready) begin
            o_type <= miss_t;
            o_addr <= cpu_addr;
            o_data <= '0;
            phase  <= P_MISS;
          end
        end
        P_MISS: begin
          if (out_ready) begin
            o_vld <= 1'b0;
            phase <= P_WAIT;
          end
        end
        P_RWB: begin
          if (out_ready) begin
            o_vld <= 1'b0;
            phase <= P_IDLE;
          end
        end
        P_WAIT: begin
          if (reply) begin
            lst   <= cpu_write ? L_EXC : L_SHD;
            tag   <= cpu_addr;
            word  <= cpu_write ? cpu_wdata : in_data;
            phase <= P_IDLE;
          end else if (own_msg && in_type == T_INV && lst == L_SHD) begin
            lst <= L_INV;
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_addr) && $stable(out_data)); // R11
  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid); // R2
  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && idle |=> !out_valid); // R5
  AST_HOME_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && idle |-> !cpu_ready); // R12
  AST_EXC_VIA_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    lst == L_EXC && $past(lst) != L_EXC |-> $past(reply)); // R4
  AST_WB_FROM_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_vld) && o_type == T_WB |-> $past(lst) == L_EXC); // R7
  AST_INV_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_type == T_INV && lst == L_SHD && in_addr == tag |=> lst == L_INV); // R6

endmodule

// File: tb/test_dir_cache_ctrl.sv
module test_dir_cache_ctrl;
  logic clk = 0, rst_n = 0;
  logic cpu_valid = 0, cpu_write = 0;
  logic [15:0] cpu_addr = 0;
  logic [31:0] cpu_wdata = 0;
  logic cpu_ready;
  logic [31:0] cpu_rdata;
  logic out_valid, out_ready = 1;
  logic [2:0] out_type;
  logic [3:0] out_node;
  logic [15:0] out_addr;
  logic [31:0] out_data;
  logic in_valid = 0, in_ready;
  logic [2:0] in_type = 0;
  logic [15:0] in_addr = 0;
  logic [31:0] in_data = 0;
  logic [1:0] line_state;

  int checks = 0, failures = 0;
  logic [50:0] exp_q[$];
  string req_q[$];

  always #5 clk = ~clk;

  dir_cache_ctrl i_dir_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type), .out_node(out_node),
    .out_addr(out_addr), .out_data(out_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_addr(in_addr), .in_data(in_data),
    .line_state(line_state)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic expect_msg(logic [2:0] t, logic [15:0] a, logic [31:0] d, string r);
    exp_q.push_back({t, a, d});
    req_q.push_back(r);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL unexpected message actual=%h expected=none", {out_type, out_addr, out_data});
      end else begin
        automatic logic [50:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        chk({r, " msg"}, {13'd0, out_type, out_addr}, {13'd0, e[50:48], e[47:32]});
        chk({r, " data"}, out_data, e[31:0]);
        chk("R3 node", {28'd0, out_node}, 32'd3);
      end
    end
  end

  task automatic hit(logic wr, logic [15:0] a, logic [31:0] wd, logic [31:0] exp_rd, string r);
    @(posedge clk) #1;
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    chk({r, " ready"}, {31'd0, cpu_ready}, 1);
    if (!wr) chk({r, " rdata"}, cpu_rdata, exp_rd);
    @(posedge clk) #1;
    cpu_valid = 0;
    @(negedge clk);
    chk({r, " no message"}, {31'd0, out_valid}, 0);
  endtask

  task automatic miss(logic wr, logic [15:0] a, logic [31:0] wd, logic [31:0] rep, logic [1:0] st, string r);
    @(posedge clk) #1;
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    chk({r, " stall"}, {31'd0, cpu_ready}, 0);
    while (exp_q.size() != 0) @(posedge clk);
    #1;
    chk({r, " stall before reply"}, {31'd0, cpu_ready}, 0);
    in_valid = 1; in_type = 3'd6; in_addr = a; in_data = rep;
    @(negedge clk);
    chk({r, " ready on reply"}, {31'd0, cpu_ready}, 1);
    if (!wr) chk({r, " reply data"}, cpu_rdata, rep);
    @(posedge clk) #1;
    in_valid = 0; cpu_valid = 0;
    @(negedge clk);
    chk({r, " state"}, {30'd0, line_state}, {30'd0, st});
  endtask

  task automatic home(logic [2:0] t, logic [15:0] a, logic [1:0] st, string r);
    @(posedge clk) #1;
    in_valid = 1; in_type = t; in_addr = a; in_data = 0;
    @(negedge clk);
    chk({r, " in_ready"}, {31'd0, in_ready}, 1);
    @(posedge clk) #1;
    in_valid = 0;
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
    chk({r, " state"}, {30'd0, line_state}, {30'd0, st});
    chk({r, " port idle"}, {31'd0, out_valid}, 0);
  endtask

  localparam logic [15:0] A = 16'h0010, B = 16'h0030, C = 16'h0040;

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 state", {30'd0, line_state}, 0);
    chk("R1 out_valid", {31'd0, out_valid}, 0);
    chk("R1 cpu_ready", {31'd0, cpu_ready}, 0);
    chk("R1 in_ready", {31'd0, in_ready}, 1);

    expect_msg(3'd0, A, 0, "R3");
    miss(0, A, 0, 32'hAAAA0001, 2'd1, "R3");
    hit(0, A, 0, 32'hAAAA0001, "R2");

    home(3'd4, A, 2'd1, "R10 fetch while shared");
    home(3'd3, 16'h0020, 2'd1, "R10 invalidate other address");
    hit(0, A, 0, 32'hAAAA0001, "R10 data kept");

    home(3'd3, A, 2'd0, "R6");
    expect_msg(3'd0, A, 0, "R3 re-read");
    miss(0, A, 0, 32'h00005555, 2'd1, "R3 re-read");

    expect_msg(3'd1, A, 0, "R4");
    miss(1, A, 32'h0000BEEF, 32'h00001234, 2'd2, "R4");
    hit(0, A, 0, 32'h0000BEEF, "R4 written word");
    hit(1, A, 32'h0000CAFE, 0, "R5");
    hit(0, A, 0, 32'h0000CAFE, "R5 readback");

    home(3'd4, C, 2'd2, "R10 fetch other address");
    expect_msg(3'd2, A, 32'h0000CAFE, "R7");
    home(3'd4, A, 2'd1, "R7");

    expect_msg(3'd1, A, 0, "R4 from shared");
    miss(1, A, 32'h00000D0D, 32'h0, 2'd2, "R4 from shared");

    out_ready = 0;
    @(posedge clk) #1;
    in_valid = 1; in_type = 3'd5; in_addr = A;
    @(posedge clk) #1;
    in_valid = 0;
    repeat (2) @(negedge clk);
    chk("R11 held valid", {31'd0, out_valid}, 1);
    chk("R11 held type", {29'd0, out_type}, 2);
    chk("R11 held data", out_data, 32'h00000D0D);
    chk("R8 state", {30'd0, line_state}, 0);
    expect_msg(3'd2, A, 32'h00000D0D, "R8");
    @(posedge clk) #1 out_ready = 1;
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
    chk("R8 port idle", {31'd0, out_valid}, 0);

    expect_msg(3'd1, A, 0, "R4 again");
    miss(1, A, 32'h00007777, 0, 2'd2, "R4 again");
    expect_msg(3'd2, A, 32'h00007777, "R9 read evict");
    expect_msg(3'd0, B, 0, "R9 read miss");
    miss(0, B, 0, 32'h00003333, 2'd1, "R9 read");
    hit(0, B, 0, 32'h00003333, "R9 new block");

    expect_msg(3'd1, B, 0, "R4 upgrade");
    miss(1, B, 32'h00004444, 0, 2'd2, "R4 upgrade");
    expect_msg(3'd2, B, 32'h00004444, "R9 write evict");
    expect_msg(3'd1, C, 0, "R9 write miss");
    miss(1, C, 32'h00006666, 0, 2'd2, "R9 write");
    hit(0, C, 0, 32'h00006666, "R9 written word");

    @(posedge clk) #1;
    cpu_valid = 1; cpu_write = 0; cpu_addr = C;
    in_valid = 1; in_type = 3'd3; in_addr = 16'h0050;
    @(negedge clk);
    chk("R12 stall on home message", {31'd0, cpu_ready}, 0);
    @(posedge clk) #1;
    in_valid = 0;
    @(negedge clk);
    chk("R12 served next", {31'd0, cpu_ready}, 1);
    chk("R12 data", cpu_rdata, 32'h00006666);
    @(posedge clk) #1 cpu_valid = 0;
    @(negedge clk);
    chk("R12 state", {30'd0, line_state}, 2);

    repeat (3) @(posedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule